// File: doc/BRIEF.md
# Double-Buffered Serial Slot-Map Loader

This block holds the slot routing map of one time-slot interchange device. A host loads a new map over one serial data wire that passes from device to device through a whole group of parts. The bits go into a shadow shift register. While they shift, the active map keeps steering the switch. The bit that leaves the far end of each shadow register feeds the next device. At the end of the chain it returns to the host, which compares it against what it sent to confirm that the chain is intact.

When the whole chain is loaded, one shared apply strobe moves every shadow into its active register. The strobe is asynchronous to the switch clock. Each device synchronises it and waits for its own frame boundary before committing, so no frame is ever served half by the old map and half by the new. The block also runs the slot counter that defines that frame. After reset, both registers hold the identity map.

Top module: `tsi_cfg_chain`

## Requirements
- R1: While `rst` is high at a `clk` edge, the active map becomes the identity (entry k equals k) and `frame_pos_o` becomes 0. While `rst` is high at a `sclk` edge, the shadow becomes the identity map.
- R2: At a rising `sclk` edge with `shift_en` high, the shadow shifts one place toward its MSB and `sdi` enters bit 0. The word is therefore loaded MSB first. Map entry k occupies bits [k*IDXW+IDXW-1 : k*IDXW].
- R3: At a rising `sclk` edge with `shift_en` low, the shadow and `sdo` keep their values.
- R4: `sdo` is the top bit of the shadow. A bit entering `sdi` appears on `sdo` after SLOTS*IDXW shift edges, so two chained devices delay the data by twice that.
- R5: Shifting never changes `map_o`. Only a commit does.
- R6: `frame_pos_o` counts 0 to SLOTS-1 on `clk` and wraps to 0.
- R7: A rising level on `apply` passes through a two-flop synchroniser. The shadow is then copied into `map_o` at a wrap of the slot counter, and `map_o` changes only on the edge where `frame_pos_o` becomes 0.
- R8: Suppose `apply` is first sampled high at the edge that takes `frame_pos_o` to SLOTS-2. The commit then happens two edges later, at the wrap right after synchronisation. If it is first sampled one edge later, the commit waits for the next wrap, SLOTS+1 edges after that sampling edge.
- R9: Each rising level of `apply` gives exactly one commit. Holding `apply` high gives no further commit, even if the shadow changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial configuration clock |
| shift_en | input | 1 | Enables shifting on `sclk` |
| sdi | input | 1 | Serial configuration data in |
| sdo | output | 1 | Serial data out, to the next device |
| apply | input | 1 | Asynchronous apply request, level |
| frame_pos_o | output | $clog2(SLOTS) | Current slot of the frame |
| map_o | output | SLOTS*IDXW | Active slot map, entry k at bits [k*IDXW +: IDXW] |

## Verification
Two events can land in the same switch-clock cycle: a synchronised apply request and the frame wrap. When they coincide, the request must commit on that wrap and not one frame later. The bench raises `apply` at a chosen slot position so that the synchronised level reaches the wrap cycle exactly. It then counts the edges until `map_o` changes and expects exactly three. It repeats the test one slot later and expects SLOTS+2 edges. Both times it checks that the change lands where `frame_pos_o` reads 0.

// File: rtl/tsi_cfg_pkg.sv
package tsi_cfg_pkg;

  // Commit tracker states for the apply request
  typedef enum logic [1:0] {
    ARM_IDLE    = 2'd0,  // no request seen
    ARM_PENDING = 2'd1,  // request seen, waiting for frame wrap
    ARM_HELD    = 2'd2   // committed, waiting for request to drop
  } arm_state_e;

endpackage

// File: rtl/tsi_cfg_shadow.sv
module tsi_cfg_shadow #(
  parameter int SLOTS = 32,
  parameter int IDXW  = 5
) (
  input  logic                   sclk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic                   sdi,
  output logic [SLOTS*IDXW-1:0]  shadow_o,
  output logic                   sdo
);
  localparam int NBITS = SLOTS * IDXW;

  logic [NBITS-1:0] ident;
  logic [NBITS-1:0] sh_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_ident
    assign ident[k*IDXW +: IDXW] = IDXW'(k);
  end

  always_ff @(posedge sclk) begin
    if (rst) begin
      sh_q <= ident;
    end else if (shift_en) begin
      sh_q <= {sh_q[NBITS-2:0], sdi};
    end
  end

  assign shadow_o = sh_q;
  assign sdo      = sh_q[NBITS-1];

endmodule

// File: rtl/tsi_cfg_frame_ctr.sv
module tsi_cfg_frame_ctr #(
  parameter int SLOTS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [$clog2(SLOTS)-1:0] pos_o,
  output logic                     wrap_o
);
  localparam int PW = $clog2(SLOTS);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (pos_q == LAST) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o  = pos_q;
  assign wrap_o = (pos_q == LAST);

endmodule

// File: rtl/tsi_cfg_apply_sync.sv
module tsi_cfg_apply_sync
  import tsi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic apply_async,
  input  logic wrap,
  output logic commit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req;
  arm_state_e             st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], apply_async};
    end
  end

  assign req = sync_q[SYNC_STAGES-1];

  always_comb begin
    st_d     = st_q;
    commit_o = 1'b0;
    unique case (st_q)
      ARM_IDLE: begin
        if (req && wrap) begin
          commit_o = 1'b1;
          st_d     = ARM_HELD;
        end else if (req) begin
          st_d = ARM_PENDING;
        end
      end
      ARM_PENDING: begin
        if (wrap) begin
          commit_o = 1'b1;
          st_d     = ARM_HELD;
        end
      end
      ARM_HELD: begin
        if (!req) st_d = ARM_IDLE;
      end
      default: st_d = ARM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ARM_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/tsi_cfg_chain.sv
module tsi_cfg_chain #(
  parameter int SLOTS = 32,
  parameter int IDXW  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclk,
  input  logic                     shift_en,
  input  logic                     sdi,
  output logic                     sdo,
  input  logic                     apply,
  output logic [$clog2(SLOTS)-1:0] frame_pos_o,
  output logic [SLOTS*IDXW-1:0]    map_o
);
  localparam int NBITS = SLOTS * IDXW;

  logic [NBITS-1:0] shadow_q;
  logic [NBITS-1:0] ident;
  logic [NBITS-1:0] active_q;
  logic             wrap;
  logic             commit;

  for (genvar k = 0; k < SLOTS; k++) begin : g_ident
    assign ident[k*IDXW +: IDXW] = IDXW'(k);
  end

  tsi_cfg_shadow #(.SLOTS(SLOTS), .IDXW(IDXW)) u_shadow (
    .sclk     (sclk),
    .rst      (rst),
    .shift_en (shift_en),
    .sdi      (sdi),
    .shadow_o (shadow_q),
    .sdo      (sdo)
  );

  tsi_cfg_frame_ctr #(.SLOTS(SLOTS)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .pos_o  (frame_pos_o),
    .wrap_o (wrap)
  );

  tsi_cfg_apply_sync #(.SYNC_STAGES(2)) u_apply (
    .clk         (clk),
    .rst         (rst),
    .apply_async (apply),
    .wrap        (wrap),
    .commit_o    (commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= ident;
    end else if (commit) begin
      active_q <= shadow_q;
    end
  end

  assign map_o = active_q;

endmodule

// File: rtl/tsi_cfg_chain_chk.sv
module tsi_cfg_chain_chk #(
  parameter int SLOTS = 32,
  parameter int IDXW  = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sclk,
  input logic                     shift_en,
  input logic                     sdi,
  input logic [$clog2(SLOTS)-1:0] frame_pos_o,
  input logic [SLOTS*IDXW-1:0]    map_o,
  input logic [SLOTS*IDXW-1:0]    shadow
);
  localparam int PW = $clog2(SLOTS);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic [SLOTS*IDXW-1:0] ident;
  for (genvar k = 0; k < SLOTS; k++) begin : g_ident
    assign ident[k*IDXW +: IDXW] = IDXW'(k);
  end

  assert_reset_identity_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (map_o == ident && frame_pos_o == '0));

  assert_shift_entry_R2: assert property (@(posedge sclk) disable iff (rst)
    shift_en |=> shadow[0] == $past(sdi));

  assert_shift_hold_R3: assert property (@(posedge sclk) disable iff (rst)
    !shift_en |=> $stable(shadow));

  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_pos_o == LAST) |=> (frame_pos_o == '0));

  assert_frame_step_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_pos_o != LAST) |=> (frame_pos_o == $past(frame_pos_o) + 1'b1));

  assert_map_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(map_o) |-> (frame_pos_o == '0));

  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(map_o) |=> $stable(map_o));

endmodule

bind tsi_cfg_chain tsi_cfg_chain_chk #(.SLOTS(SLOTS), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sclk        (sclk),
  .shift_en    (shift_en),
  .sdi         (sdi),
  .frame_pos_o (frame_pos_o),
  .map_o       (map_o),
  .shadow      (shadow_q)
);

// File: tb/tb_tsi_cfg_chain.sv
module tb_tsi_cfg_chain;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 32;
  localparam int IDXW  = 5;
  localparam int NBITS = SLOTS * IDXW;
  localparam int PW    = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic shift_en = 1'b0;
  logic sdi = 1'b0;
  logic apply = 1'b0;
  logic mid_sd;
  logic tail_sdo;
  logic [PW-1:0] pos_h, pos_t;
  logic [NBITS-1:0] map_h, map_t;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_cfg_chain #(.SLOTS(SLOTS), .IDXW(IDXW)) dut (
    .clk(clk), .rst(rst), .sclk(sclk), .shift_en(shift_en), .sdi(sdi),
    .sdo(mid_sd), .apply(apply), .frame_pos_o(pos_h), .map_o(map_h));

  tsi_cfg_chain #(.SLOTS(SLOTS), .IDXW(IDXW)) dut_tail (
    .clk(clk), .rst(rst), .sclk(sclk), .shift_en(shift_en), .sdi(mid_sd),
    .sdo(tail_sdo), .apply(apply), .frame_pos_o(pos_t), .map_o(map_t));

  function automatic logic [NBITS-1:0] mk_ident();
    logic [NBITS-1:0] w;
    for (int k = 0; k < SLOTS; k++) w[k*IDXW +: IDXW] = IDXW'(k);
    return w;
  endfunction

  function automatic logic [NBITS-1:0] mk_scramble();
    logic [NBITS-1:0] w;
    for (int k = 0; k < SLOTS; k++) w[k*IDXW +: IDXW] = IDXW'((k * 7 + 3) % SLOTS);
    return w;
  endfunction

  function automatic logic [NBITS-1:0] mk_reverse();
    logic [NBITS-1:0] w;
    for (int k = 0; k < SLOTS; k++) w[k*IDXW +: IDXW] = IDXW'(SLOTS - 1 - k);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NBITS-1:0] act, input logic [NBITS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one serial edge; returns the chain output seen before the edge
  task automatic sbit(input logic b, input logic en, output logic seen);
    seen = tail_sdo;
    sdi = b;
    shift_en = en;
    #3 sclk = 1'b1;
    #5 sclk = 1'b0;
    #2;
  endtask

  task automatic shift_word(input logic [NBITS-1:0] w, output logic [NBITS-1:0] seen);
    logic s;
    for (int i = NBITS - 1; i >= 0; i--) begin
      sbit(w[i], 1'b1, s);
      seen[i] = s;
    end
    shift_en = 1'b0;
  endtask

  // raise apply at negedge where head slot == p; count clk edges until map moves
  task automatic apply_measure(input int p, output int edges, output logic [PW-1:0] pos_at);
    logic [NBITS-1:0] prev;
    edges = -1;
    pos_at = '1;
    do @(negedge clk); while (pos_h != PW'(p));
    apply = 1'b1;
    prev = map_h;
    for (int n = 1; n <= 4 * SLOTS; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (map_h != prev) begin
        edges = n;
        pos_at = pos_h;
        break;
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #2 sclk = 1'b1;
      #2 sclk = 1'b0;
    end
    @(negedge clk);
    rst = 1'b0;
    check(map_h == mk_ident() && map_t == mk_ident(), "R1", "identity map after reset",
          map_h, mk_ident());
    check(pos_h == '0, "R1", "slot counter at zero", NBITS'(pos_h), '0);
  endtask

  task automatic t_frame();
    logic [PW-1:0] prev;
    bit ok = 1'b1;
    prev = pos_h;
    for (int i = 0; i < 2 * SLOTS; i++) begin
      @(negedge clk);
      if (pos_h != PW'((int'(prev) + 1) % SLOTS)) ok = 1'b0;
      prev = pos_h;
    end
    check(ok, "R6", "slot counter sequence and wrap", NBITS'(pos_h), NBITS'(prev));
  endtask

  task automatic t_load_two();
    logic [NBITS-1:0] seen;
    shift_word(mk_scramble(), seen);
    check(seen == mk_ident(), "R4", "tail reset word emerges first", seen, mk_ident());
    check(map_h == mk_ident() && map_t == mk_ident(), "R5", "maps untouched mid-load",
          map_t, mk_ident());
    shift_word(mk_reverse(), seen);
    check(seen == mk_ident(), "R4", "head reset word after one word delay", seen, mk_ident());
    check(map_h == mk_ident() && map_t == mk_ident(), "R5", "maps untouched after load",
          map_h, mk_ident());
  endtask

  task automatic t_idle_edges();
    logic s0, s;
    bit ok = 1'b1;
    s0 = tail_sdo;
    for (int i = 0; i < 20; i++) begin
      sbit(1'b1, 1'b0, s);
      if (tail_sdo != s0) ok = 1'b0;
    end
    check(ok, "R3", "sdo frozen while shift disabled", NBITS'(tail_sdo), NBITS'(s0));
  endtask

  task automatic t_apply_same_cycle();
    int e;
    logic [PW-1:0] p;
    apply_measure(SLOTS - 3, e, p);
    check(e == 3, "R8", "commit on the wrap that meets the request", NBITS'(e), NBITS'(3));
    check(p == '0, "R7", "map change at slot zero", NBITS'(p), '0);
    check(map_h == mk_reverse(), "R2", "head map holds second word", map_h, mk_reverse());
    check(map_t == mk_scramble(), "R7", "tail map holds first word", map_t, mk_scramble());
  endtask

  task automatic t_hold_apply();
    logic [NBITS-1:0] seen;
    shift_word('0, seen);
    check(seen == mk_scramble(), "R4", "first word back after two-device delay",
          seen, mk_scramble());
    repeat (3 * SLOTS) @(negedge clk);
    check(map_h == mk_reverse() && map_t == mk_scramble(), "R9",
          "held apply gives no second commit", map_h, mk_reverse());
    apply = 1'b0;
    repeat (5) @(negedge clk);
    check(map_t == mk_scramble(), "R5", "shift left active map alone", map_t, mk_scramble());
  endtask

  task automatic t_apply_late();
    int e;
    logic [PW-1:0] p;
    apply_measure(SLOTS - 2, e, p);
    check(e == SLOTS + 2, "R8", "request after wrap waits a frame", NBITS'(e),
          NBITS'(SLOTS + 2));
    check(p == '0, "R7", "late commit at slot zero", NBITS'(p), '0);
    check(map_h == '0 && map_t == mk_reverse(), "R7", "maps follow shadows", map_t,
          mk_reverse());
    apply = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_frame();
    t_load_two();
    t_idle_edges();
    t_apply_same_cycle();
    t_hold_apply();
    t_apply_late();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule